// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Periodic Refresh

This block sits between a processor that presents a complete word address in one go and a dynamic memory whose address pins are shared between row and column selection. When the processor raises a request, the controller captures the address and the read/write direction. It then puts the upper (row) part of the address on the shared pins while pulling the row strobe low. A fixed number of clocks later it switches the pins to the lower (column) part and pulls the column strobe low. The chip select is active low and follows the row strobe. The direction line is forwarded to the memory for the length of the access. Data wires run directly between processor and memory and do not pass through this block.

A free-running interval timer raises a refresh request every `REF_INTERVAL` clocks. A refresh cycle pulls only the row strobe low, with the row taken from an internal refresh row counter. That counter steps by one after each refresh and wraps after the last row, so every row is refreshed once per sweep. Refresh wins over a waiting processor request. A refresh that falls due during a processor access is started as soon as that access's precharge gap ends. The processor sees `busy` while the controller is occupied and a one-cycle `accDone` pulse when its access completes. It holds `reqValid` until that pulse.

Top module: `mux_dram_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `memRasN`, `memCasN` and `memCsN` are high, and `busy` and `accDone` are low.
- R2: A request is taken only when `reqValid` is high and the controller is idle. When `memRasN` falls for that access, `memAddr` carries the row part, which is address bits [ROW_W+COL_W-1:COL_W], and it holds that value while only the row strobe is low.
- R3: `memCasN` falls exactly `RAS_TO_CAS` clocks after `memRasN` falls, with `memAddr` carrying the column part, which is address bits [COL_W-1:0]. Both strobes stay low for `CAS_CYCLES` clocks and then rise in the same cycle. `memCasN` is never low while `memRasN` is high.
- R4: During an access, `memRw` equals the captured `reqRead` (1 = read, 0 = write) and stays stable while the column strobe is low. `memCsN` is low exactly when `memRasN` is low.
- R5: `accDone` is a single-cycle pulse in the last column-strobe cycle of a processor access. `busy` is high whenever the controller is not idle. The memory strobes are high whenever `busy` is low.
- R6: After every rise of `memRasN`, it stays high for at least `PRECHARGE_CYCLES` clocks.
- R7: A refresh cycle holds `memRasN` low for exactly `REFRESH_CYCLES` clocks and never pulls `memCasN` low.
- R8: The refresh row is 0 for the first refresh after reset. It increases by one with each refresh and wraps from 2^ROW_W-1 back to 0.
- R9: Refreshes are requested every `REF_INTERVAL` clocks and take priority over requests. A request raised during a refresh is held until that refresh and its precharge are done. Under continuous processor load, successive refreshes stay within `REF_INTERVAL` ± (`RAS_TO_CAS`+`CAS_CYCLES`+`PRECHARGE_CYCLES`+2) clocks of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Processor request, held until `accDone` |
| reqRead | input | 1 | Direction of request: 1 read, 0 write |
| reqAddr | input | ROW_W+COL_W | Full word address, row part in upper bits |
| busy | output | 1 | Controller occupied (access, refresh or precharge) |
| accDone | output | 1 | One-cycle completion pulse for a processor access |
| memAddr | output | max(ROW_W,COL_W) | Shared row/column address pins |
| memRasN | output | 1 | Row strobe, active low |
| memCasN | output | 1 | Column strobe, active low |
| memCsN | output | 1 | Chip select, active low |
| memRw | output | 1 | Direction to memory: 1 read, 0 write |

## Verification
The bench watches the memory pins with a small behavioural model. The model decodes each row-strobe fall, column-strobe fall and row-strobe rise. Any row-strobe pulse without a column strobe is classified as a refresh. From these events it catches four kinds of fault: swapped or shifted address halves, a wrong RAS-to-CAS distance, a column strobe released out of step with the row strobe, and a precharge gap that is too short. Refresh rows are compared against an expected counter across more than one full wrap, which exposes a counter that skips rows, starts elsewhere or fails to wrap. A request raised in the middle of a refresh must wait until the refresh completes; a design that let it cut in would show the access before the refresh count advances. A burst of back-to-back requests checks that refresh is not starved; a design that gave the processor priority would let the gap between refreshes grow without limit.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_PRE,
    ST_REF
  } dmcState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;  // capture processor address and direction
    logic selCol;    // put column part on the shared pins
    logic selRef;    // put refresh row on the shared pins
    logic stepRef;   // advance refresh row counter
    logic accessOn;  // processor access in progress (forward direction)
  } dmcStrobe_t;

endpackage

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int RAS_TO_CAS       = 2,
  parameter int CAS_CYCLES       = 2,
  parameter int PRECHARGE_CYCLES = 2,
  parameter int REFRESH_CYCLES   = 3,
  parameter int REF_INTERVAL     = 780
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output dmcStrobe_t strb,
  output logic       rasN,
  output logic       casN,
  output logic       csN,
  output logic       busy,
  output logic       accDone
);

  localparam int MAX_A = (RAS_TO_CAS > CAS_CYCLES) ? RAS_TO_CAS : CAS_CYCLES;
  localparam int MAX_B = (PRECHARGE_CYCLES > REFRESH_CYCLES) ? PRECHARGE_CYCLES : REFRESH_CYCLES;
  localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int PH_W  = $clog2(MAX_D + 1);
  localparam int TMR_W = $clog2(REF_INTERVAL + 1);

  localparam logic [PH_W-1:0]  LD_R2C = PH_W'(RAS_TO_CAS - 1);
  localparam logic [PH_W-1:0]  LD_CAS = PH_W'(CAS_CYCLES - 1);
  localparam logic [PH_W-1:0]  LD_PRE = PH_W'(PRECHARGE_CYCLES - 1);
  localparam logic [PH_W-1:0]  LD_REF = PH_W'(REFRESH_CYCLES - 1);
  localparam logic [TMR_W-1:0] TMR_TOP = TMR_W'(REF_INTERVAL - 1);

  dmcState_t       state, nextState;
  logic [PH_W-1:0] phaseCnt, loadVal;
  logic            loadPhase, phaseLast;
  logic [TMR_W-1:0] refTmr;
  logic            refPending, tmrWrap, takeRef;

  assign phaseLast = (phaseCnt == '0);
  assign tmrWrap   = (refTmr == TMR_TOP);
  assign takeRef   = (nextState == ST_REF) && (state != ST_REF);

  always_comb begin
    nextState    = state;
    loadPhase    = 1'b0;
    loadVal      = '0;
    strb         = '0;
    unique case (state)
      ST_IDLE: begin
        if (refPending) begin
          nextState = ST_REF;
          loadPhase = 1'b1;
          loadVal   = LD_REF;
        end else if (reqValid) begin
          nextState     = ST_ROW;
          loadPhase     = 1'b1;
          loadVal       = LD_R2C;
          strb.latchReq = 1'b1;
        end
      end
      ST_ROW: begin
        if (phaseLast) begin
          nextState = ST_COL;
          loadPhase = 1'b1;
          loadVal   = LD_CAS;
        end
      end
      ST_COL: begin
        if (phaseLast) begin
          nextState = ST_PRE;
          loadPhase = 1'b1;
          loadVal   = LD_PRE;
        end
      end
      ST_PRE: begin
        if (phaseLast) begin
          if (refPending) begin
            nextState = ST_REF;
            loadPhase = 1'b1;
            loadVal   = LD_REF;
          end else begin
            nextState = ST_IDLE;
          end
        end
      end
      ST_REF: begin
        if (phaseLast) begin
          nextState    = ST_PRE;
          loadPhase    = 1'b1;
          loadVal      = LD_PRE;
          strb.stepRef = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
    strb.selCol   = (state == ST_COL);
    strb.selRef   = (state == ST_REF);
    strb.accessOn = (state == ST_ROW) || (state == ST_COL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
    end else begin
      state <= nextState;
      if (loadPhase)       phaseCnt <= loadVal;
      else if (!phaseLast) phaseCnt <= phaseCnt - 1'b1;
    end
  end

  // free-running refresh interval timer and pending flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refTmr     <= '0;
      refPending <= 1'b0;
    end else begin
      refTmr <= tmrWrap ? '0 : refTmr + 1'b1;
      if (tmrWrap)      refPending <= 1'b1;
      else if (takeRef) refPending <= 1'b0;
    end
  end

  assign rasN    = !((state == ST_ROW) || (state == ST_COL) || (state == ST_REF));
  assign casN    = (state != ST_COL);
  assign csN     = rasN;
  assign busy    = (state != ST_IDLE);
  assign accDone = (state == ST_COL) && phaseLast;

endmodule

// File: rtl/dmc_datapath.sv
module dmc_datapath
  import dmc_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int COL_W = 10
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dmcStrobe_t                    strb,
  input  logic [ROW_W+COL_W-1:0]        reqAddr,
  input  logic                          reqRead,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] memAddr,
  output logic                          memRw
);

  localparam int MUX_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic [ROW_W-1:0] rowReg, refRow;
  logic [COL_W-1:0] colReg;
  logic             rdReg;
  logic [MUX_W-1:0] rowWide, colWide, refWide;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowReg <= '0;
      colReg <= '0;
      rdReg  <= 1'b1;
      refRow <= '0;
    end else begin
      if (strb.latchReq) begin
        rowReg <= reqAddr[ROW_W+COL_W-1:COL_W];
        colReg <= reqAddr[COL_W-1:0];
        rdReg  <= reqRead;
      end
      if (strb.stepRef) refRow <= refRow + 1'b1;  // wraps naturally
    end
  end

  generate
    if (ROW_W == MUX_W) begin : g_rowFull
      assign rowWide = rowReg;
      assign refWide = refRow;
    end else begin : g_rowPad
      assign rowWide = {{(MUX_W-ROW_W){1'b0}}, rowReg};
      assign refWide = {{(MUX_W-ROW_W){1'b0}}, refRow};
    end
    if (COL_W == MUX_W) begin : g_colFull
      assign colWide = colReg;
    end else begin : g_colPad
      assign colWide = {{(MUX_W-COL_W){1'b0}}, colReg};
    end
  endgenerate

  always_comb begin
    if (strb.selRef)      memAddr = refWide;
    else if (strb.selCol) memAddr = colWide;
    else                  memAddr = rowWide;
  end

  assign memRw = strb.accessOn ? rdReg : 1'b1;

endmodule

// File: rtl/mux_dram_ctrl.sv
module mux_dram_ctrl
  import dmc_pkg::*;
#(
  parameter int ROW_W            = 12,
  parameter int COL_W            = 10,
  parameter int RAS_TO_CAS       = 2,
  parameter int CAS_CYCLES       = 2,
  parameter int PRECHARGE_CYCLES = 2,
  parameter int REFRESH_CYCLES   = 3,
  parameter int REF_INTERVAL     = 780
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic                   reqRead,
  input  logic [ROW_W+COL_W-1:0] reqAddr,
  output logic                   busy,
  output logic                   accDone,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] memAddr,
  output logic                   memRasN,
  output logic                   memCasN,
  output logic                   memCsN,
  output logic                   memRw
);

  localparam int MUX_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  dmcStrobe_t strb;

  dmc_ctrl #(
    .RAS_TO_CAS      (RAS_TO_CAS),
    .CAS_CYCLES      (CAS_CYCLES),
    .PRECHARGE_CYCLES(PRECHARGE_CYCLES),
    .REFRESH_CYCLES  (REFRESH_CYCLES),
    .REF_INTERVAL    (REF_INTERVAL)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .strb    (strb),
    .rasN    (memRasN),
    .casN    (memCasN),
    .csN     (memCsN),
    .busy    (busy),
    .accDone (accDone)
  );

  dmc_datapath #(
    .ROW_W(ROW_W),
    .COL_W(COL_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .reqAddr(reqAddr),
    .reqRead(reqRead),
    .memAddr(memAddr),
    .memRw  (memRw)
  );

endmodule

// File: rtl/mux_dram_ctrl_checker.sv
module mux_dram_ctrl_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              accDone,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRasN,
  input logic              memCasN,
  input logic              memCsN,
  input logic              memRw
);

  AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rstN)
    !memCasN |-> !memRasN);  // R3

  AST_STROBES_RISE_TOGETHER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memCasN) |-> $rose(memRasN));  // R3

  AST_ROW_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!memRasN && $past(!memRasN) && memCasN && $past(memCasN)) |-> $stable(memAddr));  // R2

  AST_CS_FOLLOWS_RAS: assert property (@(posedge clk) disable iff (!rstN)
    memCsN == memRasN);  // R4

  AST_RW_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!memCasN && $past(!memCasN)) |-> $stable(memRw));  // R4

  AST_IDLE_PINS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (memRasN && memCasN && memCsN));  // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    accDone |=> !accDone);  // R5

  AST_DONE_AT_CAS: assert property (@(posedge clk) disable iff (!rstN)
    accDone |-> (!memCasN && busy));  // R5

  AST_MIN_PRECHARGE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memRasN) |=> memRasN);  // R6

endmodule

bind mux_dram_ctrl mux_dram_ctrl_checker #(.ADDR_W(MUX_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .busy   (busy),
  .accDone(accDone),
  .memAddr(memAddr),
  .memRasN(memRasN),
  .memCasN(memCasN),
  .memCsN (memCsN),
  .memRw  (memRw)
);

// File: tb/mux_dram_ctrl_bench.sv
module mux_dram_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int RW   = 4;
  localparam int CW   = 4;
  localparam int R2C  = 2;
  localparam int CASC = 2;
  localparam int PREC = 2;
  localparam int REFC = 3;
  localparam int RINT = 50;
  localparam int SLACK = R2C + CASC + PREC + 2;

  typedef struct packed {
    logic [7:0] addr;
    logic       rd;
    logic [3:0] expRow;
    logic [3:0] expCol;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'hA5, 1'b1, 4'hA, 4'h5},
    '{8'h3C, 1'b0, 4'h3, 4'hC},
    '{8'h00, 1'b1, 4'h0, 4'h0},
    '{8'hFF, 1'b0, 4'hF, 4'hF},
    '{8'h81, 1'b1, 4'h8, 4'h1},
    '{8'h7E, 1'b0, 4'h7, 4'hE}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqRead = 1'b1;
  logic [7:0] reqAddr = '0;
  logic       busy, accDone, memRasN, memCasN, memCsN, memRw;
  logic [3:0] memAddr;

  int nChecks = 0;
  int nFail   = 0;

  mux_dram_ctrl #(
    .ROW_W(RW), .COL_W(CW), .RAS_TO_CAS(R2C), .CAS_CYCLES(CASC),
    .PRECHARGE_CYCLES(PREC), .REFRESH_CYCLES(REFC), .REF_INTERVAL(RINT)
  ) u_mux_dram_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRead(reqRead),
    .reqAddr(reqAddr), .busy(busy), .accDone(accDone), .memAddr(memAddr),
    .memRasN(memRasN), .memCasN(memCasN), .memCsN(memCsN), .memRw(memRw)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // pin monitor acting as a simple memory model
  int cyc = 0;
  int rasFallCyc = 0, rasRiseCyc = -100, casFallCyc = 0, casGap = 0;
  int lastRefRise = 0, refreshCount = 0, casCount = 0;
  logic [3:0] rowCap = '0, colCap = '0, expRefRow = '0;
  logic rwCap = 1'b0, csCap = 1'b1, casSeen = 1'b0;
  logic prevRas = 1'b1, prevCas = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstN) begin
      if (prevRas && !memRasN) begin
        check(cyc - rasRiseCyc >= PREC, "R6 precharge gap", cyc - rasRiseCyc, PREC);
        rowCap     = memAddr;
        rasFallCyc = cyc;
        casSeen    = 1'b0;
      end
      if (prevCas && !memCasN) begin
        colCap     = memAddr;
        rwCap      = memRw;
        csCap      = memCsN;
        casGap     = cyc - rasFallCyc;
        casFallCyc = cyc;
        casSeen    = 1'b1;
        casCount++;
      end
      if (!prevRas && memRasN) begin
        rasRiseCyc = cyc;
        if (!casSeen) begin
          check(rowCap == expRefRow, "R8 refresh row", rowCap, expRefRow);
          check(cyc - rasFallCyc == REFC, "R7 refresh RAS length", cyc - rasFallCyc, REFC);
          if (refreshCount > 0) begin
            check((cyc - lastRefRise <= RINT + SLACK) && (cyc - lastRefRise >= RINT - SLACK),
                  "R9 refresh spacing", cyc - lastRefRise, RINT);
          end
          lastRefRise = cyc;
          refreshCount++;
          expRefRow = expRefRow + 4'd1;
        end else begin
          check(!prevCas && memCasN, "R3 strobes rise together", int'(memCasN), 1);
          check(cyc - casFallCyc == CASC, "R3 CAS length", cyc - casFallCyc, CASC);
        end
      end
      prevRas = memRasN;
      prevCas = memCasN;
    end
  end

  task automatic doAccess(input logic [7:0] addr, input logic rd);
    int waitCnt;
    @(negedge clk);
    reqValid = 1'b1;
    reqRead  = rd;
    reqAddr  = addr;
    waitCnt  = 0;
    do begin
      @(negedge clk);
      waitCnt++;
    end while (!accDone && waitCnt < 100);
    check(accDone == 1'b1, "R5 accDone seen", int'(accDone), 1);
    check(busy == 1'b1, "R5 busy during access", int'(busy), 1);
    reqValid = 1'b0;
    @(negedge clk);
    check(accDone == 1'b0, "R5 accDone single cycle", int'(accDone), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin : main
    int casBefore, refBefore, waitCnt;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(memRasN && memCasN && memCsN, "R1 strobes high in reset",
          int'({memRasN, memCasN, memCsN}), 7);
    check(!busy && !accDone, "R1 busy/done low in reset", int'({busy, accDone}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(memRasN && memCasN && memCsN && !busy, "R1 idle after reset",
          int'({memRasN, memCasN, memCsN, busy}), 14);

    // table of accesses
    for (int i = 0; i < 6; i++) begin
      doAccess(VECS[i].addr, VECS[i].rd);
      check(rowCap == VECS[i].expRow, "R2 row half", rowCap, VECS[i].expRow);
      check(colCap == VECS[i].expCol, "R3 column half", colCap, VECS[i].expCol);
      check(casGap == R2C, "R3 RAS to CAS", casGap, R2C);
      check(rwCap == VECS[i].rd, "R4 direction forwarded", rwCap, VECS[i].rd);
      check(csCap == 1'b0, "R4 chip select low", csCap, 0);
    end

    // R2 no request -> no column strobe
    casBefore = casCount;
    repeat (30) @(negedge clk);
    check(casCount == casBefore, "R2 no access without request", casCount, casBefore);

    // R9 request raised during a refresh waits for it
    waitCnt = 0;
    while (!((memRasN == 1'b0) && !busy == 1'b0 && memCasN) && waitCnt < 300) begin
      @(negedge clk);
      waitCnt++;
    end
    refBefore = refreshCount;
    doAccess(8'h96, 1'b1);
    check(refreshCount == refBefore + 1, "R9 refresh finished before access",
          refreshCount, refBefore + 1);
    check(rowCap == 4'h9 && colCap == 4'h6, "R9 held request served",
          int'({rowCap, colCap}), 8'h96);

    // R9 back-to-back load must not starve refresh
    refBefore = refreshCount;
    for (int k = 0; k < 60; k++) begin
      doAccess(8'(k * 37), k[0]);
    end
    check(refreshCount - refBefore >= 5, "R9 refresh under load",
          refreshCount - refBefore, 5);

    // R8 run past a full wrap of the refresh row counter
    repeat (20 * RINT) @(negedge clk);
    check(refreshCount >= 18, "R8 refresh counter wrapped", refreshCount, 18);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule